// File: doc/BRIEF.md
# Bus Address Break Comparator

This block watches the internal address and data buses of a processor core and raises a debug interrupt request when one bus access meets a programmed condition. The condition combines a break address, optional break data, the kind of cycle (instruction fetch, data read, data write, or any data access) and the access size (byte, word or either). Software programs it through a small register port. The programmed state is a control word, a status word, the break address and the break data.

The bus monitor input is a one-way stream. A cycle is taken only when `mon_valid` is high. The monitor cannot stall the bus, so there is no ready signal and no back-pressure. Every valid cycle is accepted in the clock it is presented. The monitor signals are registered once and the match is evaluated from that registered copy.

The data compare uses the bus lane that the access actually drives. A byte access always carries its data on the upper lane, whatever the address parity, so it is compared with the upper break-data byte. For a word access, bit 0 of the break address selects the lane: 0 selects the upper lane against the upper byte, 1 selects the lower lane against the lower byte. On a match, a sticky status flag is set, and the interrupt request follows that flag through an enable bit. No global interrupt mask reaches the block.

Top module: `brk_watch`

## Requirements
- R1: After reset, the control word reads 0, the status word reads 0, the break address reads 0, and `irq` is low.
- R2: Register select 0 is control, 1 is status, 2 is break address and 3 is break data. `reg_rdata` shows the selected register combinationally. Control keeps bits 7, 6:2 only, and status keeps bits 1:0 only.
- R3: Control bits 6:5 select the cycle type. 00 is instruction fetch (`mon_fetch`=1). 01 is data read (`mon_fetch`=0, `mon_write`=0). 10 is data write (`mon_fetch`=0, `mon_write`=1). 11 is any data access (`mon_fetch`=0).
- R4: Control bits 4:3 select the access size: 01 is byte only (`mon_word`=0), 10 is word only (`mon_word`=1), and 00 or 11 is either size.
- R5: A byte access matches when its address equals the break address exactly. A word access ignores bit 0 of both addresses.
- R6: When control bit 2 is 0, the bus data has no effect on a match.
- R7: When control bit 2 is 1, a byte access matches only when `mon_data[15:8]` equals break data bits 15:8, for odd and for even addresses.
- R8: When control bit 2 is 1, a word access compares `mon_data[15:8]` with break data bits 15:8 if break address bit 0 is 0. If that bit is 1, it compares `mon_data[7:0]` with break data bits 7:0.
- R9: A bus cycle with `mon_valid` low never matches. A bus cycle with control bit 7 (armed) at 0 never matches.
- R10: Status bit 0 (flag) is sticky. Writing 0 to it clears it. Writing 1 to it has no effect. A match in the same cycle as a clear leaves it set.
- R11: `irq` is high exactly while the status flag and status bit 1 (interrupt enable) are both 1.
- R12: A bus cycle presented before clock edge k sets the flag at edge k+1.
- R13: With control 0x80 and break address 0x025A, a fetch from 0x025A raises the break and a fetch from 0x0258 does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Selected register contents |
| mon_valid | input | 1 | Bus cycle present this clock |
| mon_addr | input | 16 | Bus address |
| mon_data | input | 16 | Bus data, upper and lower lanes |
| mon_word | input | 1 | 1 = word access, 0 = byte access |
| mon_write | input | 1 | 1 = write, 0 = read |
| mon_fetch | input | 1 | 1 = instruction fetch |
| irq | output | 1 | Break interrupt request |

## Verification
A bus cycle presented before edge k is captured at that edge. Its match sets the flag at edge k+1, and `irq` follows combinationally. The bench therefore drives each cycle one time unit after an edge, drops `mon_valid`, and waits one more edge. It then samples `irq` and the status readback between edges. Register reads are combinational and are sampled in the same cycle as the select. The same-cycle clear race is set up by putting the status write on edge k+1 itself.

// File: rtl/brk_pkg.sv
package brk_pkg;

  localparam int SEL_W = 2;

  localparam logic [SEL_W-1:0] SEL_CTRL = 2'd0;
  localparam logic [SEL_W-1:0] SEL_STAT = 2'd1;
  localparam logic [SEL_W-1:0] SEL_ADDR = 2'd2;
  localparam logic [SEL_W-1:0] SEL_DATA = 2'd3;

  localparam int CTRL_ARM_BIT = 7;
  localparam int CTRL_CYC_LSB = 5;
  localparam int CTRL_SZ_LSB  = 3;
  localparam int CTRL_DCE_BIT = 2;

  localparam int STAT_FLAG_BIT = 0;
  localparam int STAT_IE_BIT   = 1;

  typedef enum logic [1:0] {
    CYC_FETCH = 2'b00,
    CYC_DRD   = 2'b01,
    CYC_DWR   = 2'b10,
    CYC_DANY  = 2'b11
  } cyc_sel_e;

  typedef enum logic [1:0] {
    SZ_ANY_A = 2'b00,
    SZ_BYTE  = 2'b01,
    SZ_WORD  = 2'b10,
    SZ_ANY_B = 2'b11
  } size_sel_e;

  typedef struct packed {
    logic      armed;
    cyc_sel_e  cyc;
    size_sel_e size;
    logic      dce;
  } ctrl_t;

endpackage

// File: rtl/brk_regs.sv
module brk_regs
  import brk_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  localparam int REG_W = (ADDR_W > DATA_W) ? ADDR_W : DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              hit,
  output ctrl_t             ctrl,
  output logic [ADDR_W-1:0] brk_addr,
  output logic [DATA_W-1:0] brk_data,
  output logic              flag,
  output logic              irq_en
);

  logic wr_ctrl, wr_stat, wr_addr, wr_data;
  logic clr_req;

  always_comb begin
    wr_ctrl = reg_wr && (reg_sel == SEL_CTRL);
    wr_stat = reg_wr && (reg_sel == SEL_STAT);
    wr_addr = reg_wr && (reg_sel == SEL_ADDR);
    wr_data = reg_wr && (reg_sel == SEL_DATA);
    clr_req = wr_stat && !reg_wdata[STAT_FLAG_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl     <= '0;
      brk_addr <= '0;
      irq_en   <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl.armed <= reg_wdata[CTRL_ARM_BIT];
        ctrl.cyc   <= cyc_sel_e'(reg_wdata[CTRL_CYC_LSB +: 2]);
        ctrl.size  <= size_sel_e'(reg_wdata[CTRL_SZ_LSB +: 2]);
        ctrl.dce   <= reg_wdata[CTRL_DCE_BIT];
      end
      if (wr_addr) brk_addr <= reg_wdata[ADDR_W-1:0];
      if (wr_stat) irq_en <= reg_wdata[STAT_IE_BIT];
    end
  end

  // Break data carries no reset value; software loads it before use.
  always_ff @(posedge clk) begin
    if (wr_data) brk_data <= reg_wdata[DATA_W-1:0];
  end

  // Sticky flag: a new hit outranks a software clear.
  always_ff @(posedge clk) begin
    if (!rst_n)       flag <= 1'b0;
    else if (hit)     flag <= 1'b1;
    else if (clr_req) flag <= 1'b0;
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_sel)
      SEL_CTRL: begin
        reg_rdata[CTRL_ARM_BIT]         = ctrl.armed;
        reg_rdata[CTRL_CYC_LSB +: 2]    = ctrl.cyc;
        reg_rdata[CTRL_SZ_LSB +: 2]     = ctrl.size;
        reg_rdata[CTRL_DCE_BIT]         = ctrl.dce;
      end
      SEL_STAT: begin
        reg_rdata[STAT_FLAG_BIT] = flag;
        reg_rdata[STAT_IE_BIT]   = irq_en;
      end
      SEL_ADDR: reg_rdata = REG_W'(brk_addr);
      default:  reg_rdata = REG_W'(brk_data);
    endcase
  end

  // R10
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_req) |=> flag);

  // R10
  hit_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag);

  // R12
  flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(hit));

endmodule

// File: rtl/brk_capture.sv
module brk_capture #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mon_valid,
  input  logic [ADDR_W-1:0] mon_addr,
  input  logic [DATA_W-1:0] mon_data,
  input  logic              mon_word,
  input  logic              mon_write,
  input  logic              mon_fetch,
  output logic              cap_valid,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [DATA_W-1:0] cap_data,
  output logic              cap_word,
  output logic              cap_write,
  output logic              cap_fetch
);

  always_ff @(posedge clk) begin
    if (!rst_n) cap_valid <= 1'b0;
    else        cap_valid <= mon_valid;
  end

  // Payload is loaded only on strobed cycles; idle cycles keep the last one.
  always_ff @(posedge clk) begin
    if (mon_valid) begin
      cap_addr  <= mon_addr;
      cap_data  <= mon_data;
      cap_word  <= mon_word;
      cap_write <= mon_write;
      cap_fetch <= mon_fetch;
    end
  end

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_valid |=> !cap_valid);

endmodule

// File: rtl/brk_match.sv
module brk_match
  import brk_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  localparam int LANE_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_t             ctrl,
  input  logic [ADDR_W-1:0] brk_addr,
  input  logic [DATA_W-1:0] brk_data,
  input  logic              cap_valid,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic [DATA_W-1:0] cap_data,
  input  logic              cap_word,
  input  logic              cap_write,
  input  logic              cap_fetch,
  output logic              hit
);

  logic cyc_ok, size_ok, addr_ok, data_ok;
  logic up_eq, lo_eq;

  always_comb begin
    unique case (ctrl.cyc)
      CYC_FETCH: cyc_ok = cap_fetch;
      CYC_DRD:   cyc_ok = !cap_fetch && !cap_write;
      CYC_DWR:   cyc_ok = !cap_fetch &&  cap_write;
      default:   cyc_ok = !cap_fetch;
    endcase
  end

  always_comb begin
    unique case (ctrl.size)
      SZ_BYTE: size_ok = !cap_word;
      SZ_WORD: size_ok =  cap_word;
      default: size_ok = 1'b1;
    endcase
  end

  // Word accesses are aligned: the low address bit takes no part.
  always_comb begin
    if (cap_word) addr_ok = (cap_addr[ADDR_W-1:1] == brk_addr[ADDR_W-1:1]);
    else          addr_ok = (cap_addr == brk_addr);
  end

  // Lane selection follows the lane the access drives.
  always_comb begin
    up_eq = (cap_data[DATA_W-1:LANE_W] == brk_data[DATA_W-1:LANE_W]);
    lo_eq = (cap_data[LANE_W-1:0]      == brk_data[LANE_W-1:0]);
    if (!ctrl.dce)     data_ok = 1'b1;
    else if (!cap_word) data_ok = up_eq;
    else if (brk_addr[0]) data_ok = lo_eq;
    else               data_ok = up_eq;
  end

  assign hit = cap_valid && ctrl.armed && cyc_ok && size_ok && addr_ok && data_ok;

  // R9
  hit_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (cap_valid && ctrl.armed));

  // R4
  byte_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ctrl.size == SZ_BYTE) |-> !cap_word);

  // R3
  fetch_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ctrl.cyc == CYC_FETCH) |-> cap_fetch);

endmodule

// File: rtl/brk_watch.sv
module brk_watch
  import brk_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  localparam int REG_W = (ADDR_W > DATA_W) ? ADDR_W : DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              mon_valid,
  input  logic [ADDR_W-1:0] mon_addr,
  input  logic [DATA_W-1:0] mon_data,
  input  logic              mon_word,
  input  logic              mon_write,
  input  logic              mon_fetch,
  output logic              irq
);

  ctrl_t             ctrl;
  logic [ADDR_W-1:0] brk_addr;
  logic [DATA_W-1:0] brk_data;
  logic              flag, irq_en, hit;
  logic              cap_valid, cap_word, cap_write, cap_fetch;
  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] cap_data;

  brk_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .hit       (hit),
    .ctrl      (ctrl),
    .brk_addr  (brk_addr),
    .brk_data  (brk_data),
    .flag      (flag),
    .irq_en    (irq_en)
  );

  brk_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .mon_valid (mon_valid),
    .mon_addr  (mon_addr),
    .mon_data  (mon_data),
    .mon_word  (mon_word),
    .mon_write (mon_write),
    .mon_fetch (mon_fetch),
    .cap_valid (cap_valid),
    .cap_addr  (cap_addr),
    .cap_data  (cap_data),
    .cap_word  (cap_word),
    .cap_write (cap_write),
    .cap_fetch (cap_fetch)
  );

  brk_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl      (ctrl),
    .brk_addr  (brk_addr),
    .brk_data  (brk_data),
    .cap_valid (cap_valid),
    .cap_addr  (cap_addr),
    .cap_data  (cap_data),
    .cap_word  (cap_word),
    .cap_write (cap_write),
    .cap_fetch (cap_fetch),
    .hit       (hit)
  );

  // No global mask enters here: the request is the flag gated by its enable.
  assign irq = flag && irq_en;

  // R11
  irq_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && $rose(flag)) |-> irq);

endmodule

// File: tb/tb_brk_watch.sv
module tb_brk_watch;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        mon_valid = 1'b0;
  logic [15:0] mon_addr = 16'd0;
  logic [15:0] mon_data = 16'd0;
  logic        mon_word = 1'b0;
  logic        mon_write = 1'b0;
  logic        mon_fetch = 1'b0;
  logic        irq;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  brk_watch dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mon_valid(mon_valid),
    .mon_addr(mon_addr), .mon_data(mon_data), .mon_word(mon_word),
    .mon_write(mon_write), .mon_fetch(mon_fetch), .irq(irq)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [15:0] d);
    reg_sel = sel;
    #1;
    d = reg_rdata;
  endtask

  // Present one bus cycle; on return the flag edge has passed (R12).
  task automatic bus(input logic f, input logic w, input logic wd,
                     input logic [15:0] a, input logic [15:0] d, input logic v);
    mon_valid = v; mon_fetch = f; mon_write = w; mon_word = wd;
    mon_addr = a; mon_data = d;
    tick();
    mon_valid = 1'b0;
    tick();
  endtask

  function automatic logic want(input int cyc, input int sz, input int dce,
      input logic [15:0] ba, input logic [15:0] bd, input logic f, input logic w,
      input logic wd, input logic [15:0] a, input logic [15:0] d);
    logic c, s, ad, dt;
    case (cyc)
      0: c = f;
      1: c = !f && !w;
      2: c = !f && w;
      default: c = !f;
    endcase
    s  = (sz == 1) ? !wd : (sz == 2) ? wd : 1'b1;
    ad = wd ? (a[15:1] == ba[15:1]) : (a == ba);
    if (dce == 0) dt = 1'b1;
    else if (!wd) dt = (d[15:8] == bd[15:8]);
    else if (ba[0]) dt = (d[7:0] == bd[7:0]);
    else dt = (d[15:8] == bd[15:8]);
    return c && s && ad && dt;
  endfunction

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        if (!done) begin
          n_vec++; n_bad++;
          $display("FAIL watchdog: actual timeout expected completion");
          $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
          $finish;
        end
      end
    join_none
  end

  initial begin
    logic [15:0] r;
    logic [15:0] ba, bd, a, d;
    logic e;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    rd(2'd0, r); chk("R1 ctrl", r, 16'h0000);
    rd(2'd1, r); chk("R1 status", r, 16'h0000);
    rd(2'd2, r); chk("R1 addr", r, 16'h0000);
    chk("R1 irq", {15'd0, irq}, 16'd0);

    // R2 readback and field masking
    wr(2'd0, 16'hFFFF); rd(2'd0, r); chk("R2 ctrl mask", r, 16'h00FC);
    wr(2'd1, 16'hFFFE); rd(2'd1, r); chk("R2 status mask", r, 16'h0002);
    wr(2'd2, 16'hBEEF); rd(2'd2, r); chk("R2 addr", r, 16'hBEEF);
    wr(2'd3, 16'h1234); rd(2'd3, r); chk("R2 data", r, 16'h1234);

    // R13 fetch break example
    wr(2'd0, 16'h0080); wr(2'd2, 16'h025A); wr(2'd1, 16'h0002);
    bus(1, 0, 1, 16'h0258, 16'h0000, 1);
    chk("R13 no break 0258", {15'd0, irq}, 16'd0);
    bus(1, 0, 1, 16'h025A, 16'h0000, 1);
    chk("R13 break 025A", {15'd0, irq}, 16'd1);

    // R10 sticky: idle cycles and writing 1 keep it
    repeat (5) tick();
    rd(2'd1, r); chk("R10 sticky", r, 16'h0003);
    wr(2'd1, 16'h0003); rd(2'd1, r); chk("R10 write1 keeps", r, 16'h0003);

    // R11 enable gating
    wr(2'd1, 16'h0001); chk("R11 irq off when IE=0", {15'd0, irq}, 16'd0);
    rd(2'd1, r); chk("R11 flag held", r, 16'h0001);
    wr(2'd1, 16'h0003); chk("R11 irq back on", {15'd0, irq}, 16'd1);
    wr(2'd1, 16'h0002); rd(2'd1, r); chk("R10 clear", r, 16'h0002);
    chk("R11 irq low after clear", {15'd0, irq}, 16'd0);

    // R10 match on the same edge as a clear wins
    mon_valid = 1; mon_fetch = 1; mon_write = 0; mon_word = 1;
    mon_addr = 16'h025A; mon_data = 16'h0;
    tick();
    mon_valid = 0;
    wr(2'd1, 16'h0002);
    rd(2'd1, r); chk("R10 hit beats clear", r, 16'h0003);
    wr(2'd1, 16'h0002);

    // R9 valid low and disarmed
    bus(1, 0, 1, 16'h025A, 16'h0000, 0);
    rd(2'd1, r); chk("R9 valid low ignored", r, 16'h0002);
    wr(2'd0, 16'h0000);
    bus(1, 0, 1, 16'h025A, 16'h0000, 1);
    rd(2'd1, r); chk("R9 disarmed ignored", r, 16'h0002);

    // R3-R8 sweep over configurations and bus patterns
    bd = 16'hC3A5;
    wr(2'd3, bd);
    for (int bp = 0; bp < 2; bp++) begin
      ba = (bp == 0) ? 16'h3A54 : 16'h3A55;
      wr(2'd2, ba);
      for (int cyc = 0; cyc < 4; cyc++)
        for (int sz = 0; sz < 4; sz++)
          for (int dce = 0; dce < 2; dce++) begin
            wr(2'd0, 16'h0080 | 16'(cyc << 5) | 16'(sz << 3) | 16'(dce << 2));
            for (int k = 0; k < 3; k++)
              for (int wd = 0; wd < 2; wd++)
                for (int ap = 0; ap < 3; ap++)
                  for (int dp = 0; dp < 3; dp++) begin
                    a = (ap == 0) ? ba : (ap == 1) ? (ba ^ 16'h0001) : (ba ^ 16'h0100);
                    d = (dp == 0) ? bd : (dp == 1) ? {bd[15:8], ~bd[7:0]}
                                                   : {~bd[15:8], bd[7:0]};
                    wr(2'd1, 16'h0002);
                    bus(k == 0, k == 2, wd[0], a, d, 1);
                    e = want(cyc, sz, dce, ba, bd, k == 0, k == 2, wd[0], a, d);
                    // R3 R4 R5 R6 R7 R8 R12
                    chk("R3/R4/R5/R6/R7/R8 sweep irq", {15'd0, irq}, {15'd0, e});
                  end
          end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule